// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Engine

This block is a two-by-two grid of signed 8-bit multiply-accumulate cells arranged as a weight-stationary systolic array. A host first places four weights on the weight port and two activations on the activation port. It then pulses start. A phase sequencer captures both operand sets. It copies the weights into per-cell shadow registers and then, in a single cycle, into the active registers. It feeds the activations one row per cycle, so that they enter skewed. Each cell passes its activation one column to the right and its running sum one row down, with one register stage per hop. The sequencer then drains the array and raises done.

Every cell's output is caught in a result register at the moment its sum becomes valid. For each column, the engine therefore holds the partial sum after the top row and the full sum after the bottom row. That gives four 16-bit results, computed with two's-complement wraparound.

The operand and result ports are plain register contents and not streams. No handshake applies to them. The start, busy and done pins are plain control and status signals.

Top module: `wsmx_engine`

## Requirements
- R1: An active-low reset clears busy, done, all four results, the sequencer and every cell register. This holds even in the middle of a computation.
- R2: A start pulse seen while the engine is idle or done moves it out of that state. Busy reads 1 and done reads 0 on the following cycle.
- R3: Busy stays high for exactly ROWS+COLS+2 cycles (6 with the defaults). Done rises in the cycle that busy falls.
- R4: The result for column c and row r appears on result_o bits [(c*ROWS+r)*16 +: 16]. Its value is the sum over k = 0..r of act[k]*w[k][c]. Weight w[r][c] sits on weight_i bits [(r*COLS+c)*8 +: 8], and activation k sits on act_i bits [k*8 +: 8]. All operands are two's-complement.
- R5: Each product is sign-extended to 16 bits, and the sums wrap modulo 2^16 with no saturation. For example, two products of (-128)*(-128) add up to 0x8000.
- R6: Weights and activations are sampled only in the first busy cycle. Changing weight_i or act_i later in the run has no effect on that run's results.
- R7: A start pulse while busy is ignored. The run in progress keeps its timing and its results.
- R8: Done stays high until the next accepted start or a reset, and the results hold their values for that whole time. A start from the done state lowers done on the next cycle.
- R9: The phases follow the order idle, weight load (1 cycle), weight switch (1 cycle), feed (ROWS cycles), drain (COLS cycles), done.
- R10: While busy is low, result_o does not change on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| weight_i | input | ROWS*COLS*8 | Weight register file, w[r][c] at [(r*COLS+c)*8 +: 8] |
| act_i | input | ROWS*8 | Activation register file, row k at [k*8 +: 8] |
| busy_o | output | 1 | High from the cycle after start until the done phase |
| done_o | output | 1 | High in the done phase |
| result_o | output | ROWS*COLS*16 | Partial sums, column c row r at [(c*ROWS+r)*16 +: 16] |

## Verification
A sequencer that skips or repeats a phase shows up directly at the pins. The falling edge of busy and the rising edge of done move away from the sixth cycle after start, so the error appears within one run. If the shadow-to-active copy or the row skew is wrong, the first done shows wrong sums. A skew error shows mainly in the bottom-row results, while the top-row results stay correct. A pipeline register that is not cleared between runs stays hidden until a second run reads stale partial sums. Back-to-back runs with different operands are therefore needed to expose it.

// File: rtl/wsmx_pkg.sv
package wsmx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD_W = 3'd1,
    PH_SWITCH = 3'd2,
    PH_FEED   = 3'd3,
    PH_DRAIN  = 3'd4,
    PH_DONE   = 3'd5
  } phase_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wsmx_ctrl.sv
module wsmx_ctrl
  import wsmx_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int COLS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output phase_e             phase_o,
  output logic [$clog2(max_int(ROWS, COLS) + 1)-1:0] step_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(max_int(ROWS, COLS) + 1);

  phase_e             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PH_IDLE, PH_DONE: if (start_i) state_d = PH_LOAD_W;
      PH_LOAD_W:        state_d = PH_SWITCH;
      PH_SWITCH: begin
        state_d = PH_FEED;
        cnt_d   = '0;
      end
      PH_FEED: begin
        if (cnt_q == CNT_W'(ROWS - 1)) begin
          state_d = PH_DRAIN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DRAIN: begin
        if (cnt_q == CNT_W'(COLS - 1)) begin
          state_d = PH_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = state_q;
  assign step_o  = cnt_q;
  assign busy_o  = (state_q != PH_IDLE) && (state_q != PH_DONE);
  assign done_o  = (state_q == PH_DONE);

endmodule

// File: rtl/wsmx_pe.sv
module wsmx_pe #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     load_w_i,
  input  logic                     switch_i,
  input  logic signed [DATA_W-1:0] wgt_i,
  input  logic signed [DATA_W-1:0] act_i,
  input  logic                     act_vld_i,
  input  logic        [ACC_W-1:0]  psum_i,
  output logic signed [DATA_W-1:0] act_o,
  output logic                     act_vld_o,
  output logic        [ACC_W-1:0]  psum_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] w_shadow_q, w_active_q;
  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;

  assign prod     = act_i * w_active_q;
  assign prod_ext = ACC_W'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_shadow_q <= '0;
      w_active_q <= '0;
      act_o      <= '0;
      act_vld_o  <= 1'b0;
      psum_o     <= '0;
    end else begin
      if (load_w_i) w_shadow_q <= wgt_i;
      if (switch_i) w_active_q <= w_shadow_q;
      if (clear_i) begin
        act_o     <= '0;
        act_vld_o <= 1'b0;
        psum_o    <= '0;
      end else begin
        act_o     <= act_i;
        act_vld_o <= act_vld_i;
        psum_o    <= psum_i + prod_ext;
      end
    end
  end

endmodule

// File: rtl/wsmx_array.sv
module wsmx_array #(
  parameter int ROWS   = 2,
  parameter int COLS   = 2,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          load_w_i,
  input  logic                          switch_i,
  input  logic [ROWS*COLS*DATA_W-1:0]   wgt_i,
  input  logic [ROWS*DATA_W-1:0]        row_act_i,
  input  logic [ROWS-1:0]               row_vld_i,
  output logic [ROWS*COLS*ACC_W-1:0]    psum_o,
  output logic [ROWS*COLS-1:0]          vld_o
);
  logic [DATA_W-1:0] act_q  [ROWS][COLS];
  logic              vld_q  [ROWS][COLS];
  logic [ACC_W-1:0]  psum_q [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DATA_W-1:0] a_in;
      logic              v_in;
      logic [ACC_W-1:0]  p_in;

      if (c == 0) begin : g_west
        assign a_in = row_act_i[r*DATA_W +: DATA_W];
        assign v_in = row_vld_i[r];
      end else begin : g_inner
        assign a_in = act_q[r][c-1];
        assign v_in = vld_q[r][c-1];
      end

      if (r == 0) begin : g_top
        assign p_in = '0;
      end else begin : g_below
        assign p_in = psum_q[r-1][c];
      end

      wsmx_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) pe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .load_w_i  (load_w_i),
        .switch_i  (switch_i),
        .wgt_i     (wgt_i[(r*COLS+c)*DATA_W +: DATA_W]),
        .act_i     (a_in),
        .act_vld_i (v_in),
        .psum_i    (p_in),
        .act_o     (act_q[r][c]),
        .act_vld_o (vld_q[r][c]),
        .psum_o    (psum_q[r][c])
      );

      assign psum_o[(r*COLS+c)*ACC_W +: ACC_W] = psum_q[r][c];
      assign vld_o[r*COLS+c]                    = vld_q[r][c];
    end
  end

endmodule

// File: rtl/wsmx_engine.sv
module wsmx_engine
  import wsmx_pkg::*;
#(
  parameter int ROWS   = 2,
  parameter int COLS   = 2,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [ROWS*COLS*DATA_W-1:0] weight_i,
  input  logic [ROWS*DATA_W-1:0]      act_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [ROWS*COLS*ACC_W-1:0]  result_o
);
  localparam int CNT_W = $clog2(max_int(ROWS, COLS) + 1);
  localparam int NPE   = ROWS * COLS;

  phase_e                  phase;
  logic [CNT_W-1:0]        step;
  logic                    load_w, switch_w;
  logic [ROWS*DATA_W-1:0]  act_hold_q;
  logic [ROWS*DATA_W-1:0]  row_act;
  logic [ROWS-1:0]         row_vld;
  logic [NPE*ACC_W-1:0]    pe_psum;
  logic [NPE-1:0]          pe_vld;
  logic [NPE*ACC_W-1:0]    res_q;

  wsmx_ctrl #(.ROWS(ROWS), .COLS(COLS)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .phase_o (phase),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign load_w   = (phase == PH_LOAD_W);
  assign switch_w = (phase == PH_SWITCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_hold_q <= '0;
    else if (load_w) act_hold_q <= act_i;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_skew
    assign row_vld[r] = (phase == PH_FEED) && (step == CNT_W'(r));
    assign row_act[r*DATA_W +: DATA_W] =
      row_vld[r] ? act_hold_q[r*DATA_W +: DATA_W] : '0;
  end

  wsmx_array #(
    .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) array_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (load_w),
    .load_w_i  (load_w),
    .switch_i  (switch_w),
    .wgt_i     (weight_i),
    .row_act_i (row_act),
    .row_vld_i (row_vld),
    .psum_o    (pe_psum),
    .vld_o     (pe_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (pe_vld[r*COLS+c])
            res_q[(c*ROWS+r)*ACC_W +: ACC_W] <= pe_psum[(r*COLS+c)*ACC_W +: ACC_W];
        end
      end
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/wsmx_engine_chk.sv
module wsmx_engine_chk
  import wsmx_pkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 2,
  parameter int ACC_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic                       busy_o,
  input logic                       done_o,
  input logic [ROWS*COLS*ACC_W-1:0] result_o,
  input phase_e                     phase
);
  localparam int LAT = ROWS + COLS + 2;
  localparam int CW  = $clog2(LAT + 2);

  logic [CW-1:0] busy_cnt_q;
  logic          accept;

  assign accept = start_i && ((phase == PH_IDLE) || (phase == PH_DONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 busy_cnt_q <= '0;
    else if (accept)                            busy_cnt_q <= '0;
    else if (busy_o && busy_cnt_q != {CW{1'b1}}) busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  // R2
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o && !done_o);

  // R3
  a_r3_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> busy_cnt_q == CW'(LAT));

  // R7
  a_r7_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> phase != PH_LOAD_W);

  // R8
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(result_o));

  // R9
  a_r9_switch_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SWITCH |-> $past(phase) == PH_LOAD_W);

  a_r9_feed_after_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FEED && $past(phase) != PH_FEED) |-> $past(phase) == PH_SWITCH);

  a_r9_drain_after_feed: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAIN && $past(phase) != PH_DRAIN) |-> $past(phase) == PH_FEED);

  a_r9_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(phase) == PH_DRAIN);

  // R10
  a_r10_results_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(result_o));

endmodule

bind wsmx_engine wsmx_engine_chk #(
  .ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .phase    (phase)
);

// File: tb/wsmx_engine_tb_top.sv
module wsmx_engine_tb_top;
  localparam int ROWS = 2;
  localparam int COLS = 2;
  localparam int LAT  = ROWS + COLS + 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [ROWS*COLS*8-1:0] weight_i = '0;
  logic [ROWS*8-1:0]  act_i = '0;
  logic               busy_o, done_o;
  logic [ROWS*COLS*16-1:0] result_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] wv [ROWS*COLS];
  logic [7:0] av [ROWS];

  always #5 clk = ~clk;

  wsmx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .weight_i(weight_i), .act_i(act_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_sum(input int c, input int r);
    logic [15:0] acc;
    logic signed [15:0] p;
    acc = '0;
    for (int k = 0; k <= r; k++) begin
      p   = $signed(av[k]) * $signed(wv[k*COLS+c]);
      acc = acc + p;
    end
    return acc;
  endfunction

  task automatic check_results(input string req);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        check(result_o[(c*ROWS+r)*16 +: 16] == exp_sum(c, r), req, "result",
              32'(result_o[(c*ROWS+r)*16 +: 16]), 32'(exp_sum(c, r)));
  endtask

  // Called right after a negedge; returns right after the negedge where done rises.
  task automatic run_op(input string req, input bit poke_ops, input bit poke_start);
    for (int i = 0; i < ROWS*COLS; i++) weight_i[i*8 +: 8] = wv[i];
    for (int i = 0; i < ROWS; i++)      act_i[i*8 +: 8]    = av[i];
    start_i = 1'b1;
    for (int i = 1; i <= LAT + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin
        start_i = 1'b0;
        check(busy_o && !done_o, "R2", "busy after start", {busy_o, done_o}, 2'b10);
        check(!done_o, "R8", "done cleared by start", done_o, 0);
      end
      if (poke_ops && i == 2) begin
        weight_i = {$urandom, $urandom};
        act_i    = 16'($urandom);
      end
      if (poke_start && i == 3) start_i = 1'b1;
      if (poke_start && i == 4) start_i = 1'b0;
      if (i == LAT)
        check(busy_o && !done_o, "R3", "last busy cycle (R9 order)", {busy_o, done_o}, 2'b10);
      if (i == LAT + 1)
        check(!busy_o && done_o, "R3", "done rises", {busy_o, done_o}, 2'b01);
    end
    check_results(req);
  endtask

  task automatic rand_ops();
    for (int i = 0; i < ROWS*COLS; i++) wv[i] = 8'($urandom);
    for (int i = 0; i < ROWS; i++)      av[i] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [ROWS*COLS*16-1:0] snap;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o, "R1", "flags after reset", {busy_o, done_o}, 0);
    check(result_o == '0, "R1", "results after reset", 32'(result_o), 0);

    // R4 directed: zeros then plain values
    foreach (wv[i]) wv[i] = 8'd0;
    foreach (av[i]) av[i] = 8'd0;
    run_op("R4", 1'b0, 1'b0);
    wv[0] = 8'd3; wv[1] = 8'd5; wv[2] = 8'd7; wv[3] = 8'hFE;
    av[0] = 8'd2; av[1] = 8'hFD;
    run_op("R4", 1'b0, 1'b0);

    // R8 done holds and results stay while idle in done
    snap = result_o;
    repeat (4) @(negedge clk);
    check(done_o && !busy_o, "R8", "done held", {busy_o, done_o}, 2'b01);
    check(result_o == snap, "R10", "results held in done", 32'(result_o), 32'(snap));

    // R5 wraparound corners
    foreach (wv[i]) wv[i] = 8'h80;
    foreach (av[i]) av[i] = 8'h80;
    run_op("R5", 1'b0, 1'b0);
    foreach (wv[i]) wv[i] = 8'h7F;
    av[0] = 8'h80; av[1] = 8'h80;
    run_op("R5", 1'b0, 1'b0);
    foreach (wv[i]) wv[i] = 8'h7F;
    foreach (av[i]) av[i] = 8'h7F;
    run_op("R5", 1'b0, 1'b0);

    // R6 operands changed mid-run, R7 start while busy
    rand_ops(); run_op("R6", 1'b1, 1'b0);
    rand_ops(); run_op("R7", 1'b0, 1'b1);

    // R1 reset mid-run
    rand_ops();
    for (int i = 0; i < ROWS*COLS; i++) weight_i[i*8 +: 8] = wv[i];
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o, "R1", "flags after mid-run reset", {busy_o, done_o}, 0);
    check(result_o == '0, "R1", "results after mid-run reset", 32'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1", "idle after release", {busy_o, done_o}, 0);

    // random runs, back to back from idle and from done
    for (int n = 0; n < 40; n++) begin
      rand_ops();
      run_op("R4", n[0], n[1] & n[2]);
      if (n[3]) repeat (2) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule